// File: doc/BRIEF.md
# Byte-Bus Parallel Pin Port

This block gives a processor byte-level control over a set of general-purpose pins through a small register window. It contains two bidirectional ports and one input-only port. Each bidirectional port has two registers. The first is a direction register, in which a 1 bit makes the pin an output and a 0 bit makes it an input. The second is a data register that holds the output latch. Each bidirectional pin leaves the block as a value and an enable, one per bit, ready to feed a tri-state pad. The input-only port has no direction register and no latch.

Reads of a data register merge two sources. For output bits the read returns the latch. For input bits it returns the pin level after a synchronizer, so a read-modify-write on one output bit leaves the other output bits intact. The direction register cannot be read back: it always returns all ones. A read-modify-write aimed at a direction register therefore turns every pin of that port into an output. Software must write whole bytes to it.

The bus uses plain strobes. A read strobe is answered by a registered data byte with a valid flag in the next cycle. Nothing can stall the bus, so there is no back-pressure: a read is always answered one cycle after its strobe, and a write always takes effect at the edge that samples it.

Top module: `pio_block`

## Requirements
- R1: While reset is asserted, and after it is released with no write, every output enable and every output value is 0, and the read-valid flag is 0.
- R2: A write to a direction register (port A at offset 1, port B at offset 4) sets each bit of that port's output enable to the written bit, for each bit on its own, from the cycle after the write edge.
- R3: A read of a direction register returns 8'hFF, whatever value it holds.
- R4: A read of a bidirectional data register (port A at offset 3, port B at offset 6) returns, per bit, the output latch where the direction bit is 1 and the synchronized pin level where it is 0.
- R5: The output latch keeps the last written value until the next write to its offset. A write to an input bit changes neither that bit's enable nor the level read from it.
- R6: Writing 1s to a data register before setting its direction bits makes each pin's value 1 on the same cycle its enable rises, so the pin never drives 0.
- R7: The two bidirectional ports are independent. An access at one port's offsets leaves the other port's registers and pins unchanged.
- R8: A read of the input-only port (offset 8) always returns its synchronized pin levels, and writes to that offset have no effect.
- R9: Writes to unmapped offsets (every offset except 1, 3, 4, 6 and 8) are ignored, and reads of them return 8'h00.
- R10: The read-valid flag is 1 in exactly the cycle after a read strobe. A pin change set up before edge k is returned by a read sampled at edge k+2 and not by one sampled at edge k or k+1, with the default two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A per-bit output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B per-bit output enables |
| pc_in | input | 8 | Input-only port pin levels |

## Verification
A write changes a latch, an enable or a pin value at the edge that samples the strobe. The bench drives each strobe on a falling edge and reads the pins at the next falling edge, half a cycle after the update. Read data and its valid flag are due one edge after the read strobe, so each read task raises the strobe for one cycle and samples on the following falling edge. A pin change needs two more edges to cross the synchronizer. A directed test holds the read strobe over three consecutive edges and expects the old level twice and then the new level.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_A_DIR = 3'd1,
    SEL_A_DAT = 3'd2,
    SEL_B_DIR = 3'd3,
    SEL_B_DAT = 3'd4,
    SEL_C_DAT = 3'd5
  } pio_sel_e;

  localparam int PIO_OFS_A_DIR = 1;
  localparam int PIO_OFS_A_DAT = 3;
  localparam int PIO_OFS_B_DIR = 4;
  localparam int PIO_OFS_B_DAT = 6;
  localparam int PIO_OFS_C_DAT = 8;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pio_bidir.sv
module pio_bidir #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_dat,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_view
);
  logic [W-1:0] dir_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_dat) lat_q <= wdata;
    end
  end

  pio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign pin_o[b]   = lat_q[b];
      assign pin_oe[b]  = dir_q[b];
      assign rd_view[b] = dir_q[b] ? lat_q[b] : pin_s[b];
    end
  endgenerate
endmodule

// File: rtl/pio_inonly.sv
module pio_inonly #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rd_view
);
  pio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(rd_view)
  );
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int AW    = 4,
  parameter int A_DIR = PIO_OFS_A_DIR,
  parameter int A_DAT = PIO_OFS_A_DAT,
  parameter int B_DIR = PIO_OFS_B_DIR,
  parameter int B_DAT = PIO_OFS_B_DAT,
  parameter int C_DAT = PIO_OFS_C_DAT
) (
  input  logic [AW-1:0] addr,
  output pio_sel_e      sel
);
  always_comb begin
    sel = SEL_NONE;
    if      (addr == AW'(A_DIR)) sel = SEL_A_DIR;
    else if (addr == AW'(A_DAT)) sel = SEL_A_DAT;
    else if (addr == AW'(B_DIR)) sel = SEL_B_DIR;
    else if (addr == AW'(B_DAT)) sel = SEL_B_DAT;
    else if (addr == AW'(C_DAT)) sel = SEL_C_DAT;
  end
endmodule

// File: rtl/pio_block.sv
module pio_block
  import pio_pkg::*;
#(
  parameter int W      = 8,
  parameter int AW     = 4,
  parameter int STAGES = 2,
  parameter int A_DIR  = PIO_OFS_A_DIR,
  parameter int A_DAT  = PIO_OFS_A_DAT,
  parameter int B_DIR  = PIO_OFS_B_DIR,
  parameter int B_DAT  = PIO_OFS_B_DAT,
  parameter int C_DAT  = PIO_OFS_C_DAT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_rvalid,
  input  logic [W-1:0]  pa_in,
  output logic [W-1:0]  pa_out,
  output logic [W-1:0]  pa_oe,
  input  logic [W-1:0]  pb_in,
  output logic [W-1:0]  pb_out,
  output logic [W-1:0]  pb_oe,
  input  logic [W-1:0]  pc_in
);
  localparam logic [W-1:0] DIR_READBACK = '1;

  pio_sel_e     sel;
  logic [W-1:0] a_view, b_view, c_view;
  logic [W-1:0] rd_next;

  pio_decode #(
    .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT),
    .B_DIR(B_DIR), .B_DAT(B_DAT), .C_DAT(C_DAT)
  ) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  pio_bidir #(.W(W), .STAGES(STAGES)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(bus_wr && sel == SEL_A_DIR),
    .wr_dat(bus_wr && sel == SEL_A_DAT),
    .wdata(bus_wdata), .pin_i(pa_in),
    .pin_o(pa_out), .pin_oe(pa_oe), .rd_view(a_view)
  );

  pio_bidir #(.W(W), .STAGES(STAGES)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(bus_wr && sel == SEL_B_DIR),
    .wr_dat(bus_wr && sel == SEL_B_DAT),
    .wdata(bus_wdata), .pin_i(pb_in),
    .pin_o(pb_out), .pin_oe(pb_oe), .rd_view(b_view)
  );

  pio_inonly #(.W(W), .STAGES(STAGES)) u_port_c (
    .clk(clk), .rst_n(rst_n), .pin_i(pc_in), .rd_view(c_view)
  );

  always_comb begin
    unique case (sel)
      SEL_A_DIR, SEL_B_DIR: rd_next = DIR_READBACK;
      SEL_A_DAT:            rd_next = a_view;
      SEL_B_DAT:            rd_next = b_view;
      SEL_C_DAT:            rd_next = c_view;
      default:              rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pio_block_chk.sv
module pio_block_chk #(
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int A_DIR = 1,
  parameter int A_DAT = 3,
  parameter int B_DIR = 4,
  parameter int B_DAT = 6,
  parameter int C_DAT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic          bus_rvalid,
  input logic [W-1:0]  pa_oe,
  input logic [W-1:0]  pb_oe
);
  logic unmapped;
  assign unmapped = bus_addr != AW'(A_DIR) && bus_addr != AW'(A_DAT) &&
                    bus_addr != AW'(B_DIR) && bus_addr != AW'(B_DAT) &&
                    bus_addr != AW'(C_DAT);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (pa_oe == '0 && pb_oe == '0 && !bus_rvalid); // R1
    end
  end

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R10
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R10
  AST_OE_TRACKS_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(A_DIR)) |=> pa_oe == $past(bus_wdata)); // R2
  AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == AW'(A_DIR) || bus_addr == AW'(B_DIR))) |=> bus_rdata == '1); // R3
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> bus_rdata == '0); // R9
  AST_A_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(A_DIR)) |=> $stable(pa_oe)); // R7
  AST_B_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(B_DIR)) |=> $stable(pb_oe)); // R7
endmodule

bind pio_block pio_block_chk #(
  .W(W), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT),
  .B_DIR(B_DIR), .B_DAT(B_DAT), .C_DAT(C_DAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .pa_oe(pa_oe), .pb_oe(pb_oe)
);

// File: tb/sim_pio_block.sv
module sim_pio_block;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pio_block u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in)
  );

  // {is_read, addr, data (write value or expected read), requirement number}
  localparam int NV = 23;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 4'd3,  8'hA5, 4'd4},  // R4 all input: pins
    {1'b1, 4'd1,  8'hFF, 4'd3},  // R3
    {1'b0, 4'd3,  8'h0F, 4'd5},
    {1'b1, 4'd3,  8'hA5, 4'd5},  // R5 latch hidden on input bits
    {1'b0, 4'd1,  8'h0F, 4'd2},
    {1'b1, 4'd3,  8'hAF, 4'd4},  // R4 mixed
    {1'b1, 4'd1,  8'hFF, 4'd3},  // R3
    {1'b0, 4'd6,  8'hC3, 4'd7},
    {1'b0, 4'd4,  8'hF0, 4'd7},
    {1'b1, 4'd6,  8'hCC, 4'd7},  // R7 port B mixed
    {1'b1, 4'd3,  8'hAF, 4'd7},  // R7 port A untouched
    {1'b1, 4'd8,  8'h5A, 4'd8},  // R8
    {1'b0, 4'd8,  8'h00, 4'd8},
    {1'b1, 4'd8,  8'h5A, 4'd8},  // R8 write ignored
    {1'b0, 4'd0,  8'hFF, 4'd9},
    {1'b1, 4'd0,  8'h00, 4'd9},  // R9
    {1'b0, 4'd2,  8'hFF, 4'd9},
    {1'b1, 4'd3,  8'hAF, 4'd9},  // R9 write at offset 2 ignored
    {1'b1, 4'd15, 8'h00, 4'd9},  // R9
    {1'b0, 4'd7,  8'hFF, 4'd9},
    {1'b1, 4'd6,  8'hCC, 4'd9},  // R9 write at offset 7 ignored
    {1'b1, 4'd4,  8'hFF, 4'd3},  // R3 port B direction
    {1'b0, 4'd5,  8'h00, 4'd9}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] rd;
    logic       rv;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 oe in reset", pa_oe | pb_oe, 8'h00);
    check("R1 out in reset", pa_out | pb_out, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 oe after reset", pa_oe | pb_oe, 8'h00);
    check("R1 rvalid idle", {7'd0, bus_rvalid}, 8'h00);

    pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'h5A;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        do_read(VEC[i][15:12], rd, rv);
        check($sformatf("R%0d vec %0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
        check($sformatf("R10 rvalid vec %0d", i), {7'd0, rv}, 8'h01);
      end else begin
        do_write(VEC[i][15:12], VEC[i][11:4]);
      end
    end
    check("R2 pa_oe", pa_oe, 8'h0F);
    check("R5 pa_out latch", pa_out, 8'h0F);
    check("R7 pb_oe", pb_oe, 8'hF0);
    check("R7 pb_out", pb_out, 8'hC3);

    // R2 per-bit enables
    do_write(4'd1, 8'h81);
    check("R2 per-bit oe", pa_oe, 8'h81);
    // R5 latch holds with no write
    repeat (5) @(negedge clk);
    check("R5 latch held", pa_out, 8'h0F);
    check("R10 rvalid drops", {7'd0, bus_rvalid}, 8'h00);

    // R6 latch before direction: no low drive
    do_reset();
    do_write(4'd3, 8'hFF);
    check("R6 out before dir", pa_out, 8'hFF);
    check("R6 oe still off", pa_oe, 8'h00);
    do_write(4'd1, 8'hFF);
    check("R6 oe on", pa_oe, 8'hFF);
    check("R6 out high", pa_out, 8'hFF);

    // R10 synchronizer latency on port C
    do_reset();
    pc_in = 8'h11;
    repeat (4) @(negedge clk);
    pc_in = 8'hEE; bus_addr = 4'd8; bus_rd = 1'b1;
    @(negedge clk);
    check("R10 edge k old", bus_rdata, 8'h11);
    @(negedge clk);
    check("R10 edge k+1 old", bus_rdata, 8'h11);
    @(negedge clk);
    check("R10 edge k+2 new", bus_rdata, 8'hEE);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R10 valid low after strobe", {7'd0, bus_rvalid}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule